// File: doc/BRIEF.md
# Panel Power Sequencer

This block takes a display controller through its wake-up handshake and its shutdown sequence. It sends each step as a request to a separate 9-bit command writer. The writer owns the serial link and acknowledges each request with a single-cycle pulse plus an error flag. The sequencer decides what to send, in what order, and when to pause. Software or a higher-level controller only raises an enable or a disable request and then watches two status outputs: `active` and a sticky `err_flag`.

Both sequences sit in one internal read-only table. Each table entry holds three fields:
- a 2-bit length code,
- an 8-bit register number,
- a 16-bit data field.

An end marker closes each sequence. Wake-up opens with three timed null commands. If any of them fails, wake-up stops there, before any configuration write is issued. Errors in the later writes do not stop the sequence. They are merged and reported once, when the panel is declared active.

The wait after each null command comes from a cycle counter. Its length is derived from the `CLK_HZ` and `WAIT_MS` parameters.

Top module: `pnl_power_seq`

## Requirements
- R1: After a synchronous reset, `active`, `err_flag` and `wr_req` are all 0.
- R2: An enable request is taken only while the block is idle and inactive, and a disable request only while it is idle and active. An enable while active, a disable while inactive, and any request during a running sequence issue no write and leave the status unchanged.
- R3: Wake-up starts with three command-only writes of register 0x00. After each one is acknowledged without error, `wr_req` stays low for at least WAIT_CYC = CLK_HZ/1000*WAIT_MS cycles.
- R4: If any of those three writes is acknowledged with `wr_err` high, no further write is issued. `err_flag` is 1 on the next cycle, and `active` stays 0.
- R5: Length codes are fixed: 1 = command only, 2 = command plus one data byte in `wr_data[7:0]`, 3 = command plus two data bytes, with `wr_data[15:8]` sent first. Code 0 is never presented with `wr_req`. After the null commands, wake-up writes these steps in this order:
  - 0xB0 with 0x17, then 0xBC with 0x80, then 0x3B with 0x00, then 0xB0 with 0x16;
  - two-byte 0xB8 with 0xFFF9;
  - command 0x11;
  - one-byte writes BA/01, BB/00, 3A/60, BF/10, B1/56, B2/33, B3/11, B3/11, B4/02, B5/2B, B6/40, B7/03, B9/04, BD/04, BE/00, C0/11, C1/11, C2/11;
  - two-byte writes C3/2040, C4/60C0, C5/1020, C6/60C0, C7/5533;
  - one-byte writes C8/00, C9/00, CA/00;
  - two-byte EC/01F0, one-byte CF/02, two-byte D0/0804, one-byte D1/01, two-byte D2/0000, two-byte D3/0D0E, two-byte D4/11A4, one-byte D5/0E;
  - finally command 0x29.
- R6: `active` rises on the second clock edge after the acknowledge of the final 0x29 command.
- R7: Errors on writes after the null commands do not stop wake-up. They are ORed together and appear on `err_flag` in the same cycle that `active` rises.
- R8: Shutdown writes, in order: command 0x28, then two-byte 0xB8 with 0x8002, then command 0x10, then one-byte 0xB0 with 0x00. `active` falls on the second edge after the last acknowledge. Errors during shutdown leave `err_flag` unchanged.
- R9: While `wr_req` is high and not yet acknowledged, `wr_len`, `wr_reg` and `wr_data` hold steady. Each acknowledge consumes exactly one write.
- R10: `err_flag` keeps its value until the next accepted enable request, which clears it on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_req | input | 1 | Request to run the wake-up sequence |
| dis_req | input | 1 | Request to run the shutdown sequence |
| wr_req | output | 1 | Write request to the command writer |
| wr_len | output | 2 | Length code of the current write |
| wr_reg | output | 8 | Register/command byte of the current write |
| wr_data | output | 16 | Data field of the current write |
| wr_ack | input | 1 | One-cycle acknowledge from the command writer |
| wr_err | input | 1 | Transfer error, valid together with `wr_ack` |
| active | output | 1 | Panel has been woken and is running |
| err_flag | output | 1 | Sticky error status |

## Verification
The properties rest on four assumptions about the writer side:
- `wr_ack` is a single-cycle pulse given only while `wr_req` is high;
- `wr_err` only has meaning alongside `wr_ack`;
- a command-only write of register 0x00 occurs nowhere but in the wake-up preamble;
- a one-byte write of 0xB0 with 0x00 occurs nowhere but at the end of shutdown.

The bench's responder keeps within these assumptions. It acknowledges only after it has seen a request, drops the acknowledge the next cycle, and injects errors only on an acknowledged write. Enable and disable are driven as one-cycle pulses, including pulses that land in the middle of a running sequence.

// File: rtl/pnl_seq_pkg.sv
// Package: shared types and table layout for the panel power sequencer.
// Assumes: the wake-up sequence starts at index 0 and the shutdown
// sequence follows the wake-up end marker in the same table.
package pnl_seq_pkg;

    // Length code of one table entry; 0 doubles as the end marker.
    typedef enum logic [1:0] {
        LEN_END = 2'd0,
        LEN_CMD = 2'd1,
        LEN_ONE = 2'd2,
        LEN_TWO = 2'd3
    } len_code_e;

    typedef struct packed {
        len_code_e   len;
        logic [7:0]  addr;
        logic [15:0] data;
    } seq_entry_t;

    localparam int unsigned WAKE_BASE   = 0;
    localparam int unsigned NULL_COUNT  = 3;
    localparam int unsigned DOWN_BASE   = 45;
    localparam int unsigned TABLE_DEPTH = 50;
    localparam int unsigned IDX_W       = $clog2(TABLE_DEPTH);

    function automatic seq_entry_t mk(len_code_e l, logic [7:0] a, logic [15:0] d);
        seq_entry_t e;
        e.len  = l;
        e.addr = a;
        e.data = d;
        return e;
    endfunction

endpackage

// File: rtl/pnl_seq_table.sv
// Module: read-only sequence table, combinational lookup by index.
// Assumes: indices past the last entry read as an end marker.
module pnl_seq_table
    import pnl_seq_pkg::*;
#(
    parameter int unsigned IW = IDX_W
) (
    input  logic [IW-1:0] idx,
    output seq_entry_t    entry
);

    int unsigned sel;
    assign sel = int'(idx);

    // Entry decode: wake-up at 0..44, shutdown at 45..49.
    always_comb begin
        case (sel)
            0, 1, 2: entry = mk(LEN_CMD, 8'h00, 16'h0000);
            3:  entry = mk(LEN_ONE, 8'hB0, 16'h0017);
            4:  entry = mk(LEN_ONE, 8'hBC, 16'h0080);
            5:  entry = mk(LEN_ONE, 8'h3B, 16'h0000);
            6:  entry = mk(LEN_ONE, 8'hB0, 16'h0016);
            7:  entry = mk(LEN_TWO, 8'hB8, 16'hFFF9);
            8:  entry = mk(LEN_CMD, 8'h11, 16'h0000);
            9:  entry = mk(LEN_ONE, 8'hBA, 16'h0001);
            10: entry = mk(LEN_ONE, 8'hBB, 16'h0000);
            11: entry = mk(LEN_ONE, 8'h3A, 16'h0060);
            12: entry = mk(LEN_ONE, 8'hBF, 16'h0010);
            13: entry = mk(LEN_ONE, 8'hB1, 16'h0056);
            14: entry = mk(LEN_ONE, 8'hB2, 16'h0033);
            15, 16: entry = mk(LEN_ONE, 8'hB3, 16'h0011);
            17: entry = mk(LEN_ONE, 8'hB4, 16'h0002);
            18: entry = mk(LEN_ONE, 8'hB5, 16'h002B);
            19: entry = mk(LEN_ONE, 8'hB6, 16'h0040);
            20: entry = mk(LEN_ONE, 8'hB7, 16'h0003);
            21: entry = mk(LEN_ONE, 8'hB9, 16'h0004);
            22: entry = mk(LEN_ONE, 8'hBD, 16'h0004);
            23: entry = mk(LEN_ONE, 8'hBE, 16'h0000);
            24: entry = mk(LEN_ONE, 8'hC0, 16'h0011);
            25: entry = mk(LEN_ONE, 8'hC1, 16'h0011);
            26: entry = mk(LEN_ONE, 8'hC2, 16'h0011);
            27: entry = mk(LEN_TWO, 8'hC3, 16'h2040);
            28: entry = mk(LEN_TWO, 8'hC4, 16'h60C0);
            29: entry = mk(LEN_TWO, 8'hC5, 16'h1020);
            30: entry = mk(LEN_TWO, 8'hC6, 16'h60C0);
            31: entry = mk(LEN_TWO, 8'hC7, 16'h5533);
            32: entry = mk(LEN_ONE, 8'hC8, 16'h0000);
            33: entry = mk(LEN_ONE, 8'hC9, 16'h0000);
            34: entry = mk(LEN_ONE, 8'hCA, 16'h0000);
            35: entry = mk(LEN_TWO, 8'hEC, 16'h01F0);
            36: entry = mk(LEN_ONE, 8'hCF, 16'h0002);
            37: entry = mk(LEN_TWO, 8'hD0, 16'h0804);
            38: entry = mk(LEN_ONE, 8'hD1, 16'h0001);
            39: entry = mk(LEN_TWO, 8'hD2, 16'h0000);
            40: entry = mk(LEN_TWO, 8'hD3, 16'h0D0E);
            41: entry = mk(LEN_TWO, 8'hD4, 16'h11A4);
            42: entry = mk(LEN_ONE, 8'hD5, 16'h000E);
            43: entry = mk(LEN_CMD, 8'h29, 16'h0000);
            44: entry = mk(LEN_END, 8'h00, 16'h0000);
            45: entry = mk(LEN_CMD, 8'h28, 16'h0000);
            46: entry = mk(LEN_TWO, 8'hB8, 16'h8002);
            47: entry = mk(LEN_CMD, 8'h10, 16'h0000);
            48: entry = mk(LEN_ONE, 8'hB0, 16'h0000);
            default: entry = mk(LEN_END, 8'h00, 16'h0000);
        endcase
    end

endmodule

// File: rtl/pnl_wait_timer.sv
// Module: one-shot down counter for the pause after each null command.
// Assumes: start is a single-cycle pulse; expired is high whenever the
// count has run out, including before the first start.
module pnl_wait_timer #(
    parameter int unsigned LOAD_VAL = 1,
    localparam int unsigned CW      = $clog2(LOAD_VAL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);

    logic [CW-1:0] cnt;

    // Load on start, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(LOAD_VAL);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/pnl_seq_ctrl.sv
// Module: sequence controller. Walks the table from the chosen base,
// holds each write request until acknowledged, pauses after each null
// command, aborts on a null-command error and collects later errors.
// Assumes: wr_ack is a one-cycle pulse given only while wr_req is high.
module pnl_seq_ctrl
    import pnl_seq_pkg::*;
#(
    parameter int unsigned IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_req,
    input  logic          dis_req,
    input  len_code_e     entry_len,
    output logic [IW-1:0] idx,
    output logic          timer_start,
    input  logic          timer_expired,
    output logic          wr_req,
    input  logic          wr_ack,
    input  logic          wr_err,
    output logic          active,
    output logic          err_flag
);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } st_e;

    st_e  state;
    logic waking;
    logic err_acc;
    logic in_null;
    logic at_end;

    assign in_null     = waking && (idx < IW'(NULL_COUNT));
    assign at_end      = (entry_len == LEN_END);
    assign wr_req      = (state == ST_ISSUE) && !at_end;
    assign timer_start = wr_req && wr_ack && in_null && !wr_err;

    // Main state machine: start, step, pause, abort and finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            waking   <= 1'b0;
            err_acc  <= 1'b0;
            active   <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (en_req && !active) begin
                        idx      <= IW'(WAKE_BASE);
                        waking   <= 1'b1;
                        err_acc  <= 1'b0;
                        err_flag <= 1'b0;
                        state    <= ST_ISSUE;
                    end else if (dis_req && active) begin
                        idx    <= IW'(DOWN_BASE);
                        waking <= 1'b0;
                        state  <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (at_end) begin
                        state <= ST_IDLE;
                        if (waking) begin
                            active   <= 1'b1;
                            err_flag <= err_acc;
                        end else begin
                            active <= 1'b0;
                        end
                    end else if (wr_ack) begin
                        idx <= idx + 1'b1;
                        if (in_null) begin
                            if (wr_err) begin
                                err_flag <= 1'b1;
                                state    <= ST_IDLE;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end else if (waking) begin
                            err_acc <= err_acc | wr_err;
                        end
                    end
                end
                ST_WAIT: begin
                    if (timer_expired) begin
                        state <= ST_ISSUE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pnl_power_seq.sv
// Module: top of the panel power sequencer. Connects the controller,
// the sequence table and the pause timer, and presents the current
// table entry to the command writer.
// Assumes: CLK_HZ is at least 1000 so that one millisecond is a whole
// number of cycles; a zero result is raised to one cycle.
module pnl_power_seq
    import pnl_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned WAIT_MS = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_req,
    input  logic        dis_req,
    output logic        wr_req,
    output logic [1:0]  wr_len,
    output logic [7:0]  wr_reg,
    output logic [15:0] wr_data,
    input  logic        wr_ack,
    input  logic        wr_err,
    output logic        active,
    output logic        err_flag
);

    localparam int unsigned RAW_CYC  = (CLK_HZ / 1000) * WAIT_MS;
    localparam int unsigned WAIT_CYC = (RAW_CYC == 0) ? 1 : RAW_CYC;

    logic [IDX_W-1:0] idx;
    seq_entry_t       entry;
    logic             t_start;
    logic             t_expired;

    pnl_seq_table #(.IW(IDX_W)) u_table (
        .idx   (idx),
        .entry (entry)
    );

    pnl_wait_timer #(.LOAD_VAL(WAIT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (t_start),
        .expired (t_expired)
    );

    pnl_seq_ctrl #(.IW(IDX_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_req        (en_req),
        .dis_req       (dis_req),
        .entry_len     (entry.len),
        .idx           (idx),
        .timer_start   (t_start),
        .timer_expired (t_expired),
        .wr_req        (wr_req),
        .wr_ack        (wr_ack),
        .wr_err        (wr_err),
        .active        (active),
        .err_flag      (err_flag)
    );

    assign wr_len  = entry.len;
    assign wr_reg  = entry.addr;
    assign wr_data = entry.data;

endmodule

// File: rtl/pnl_power_seq_chk.sv
// Module: property checker for pnl_power_seq, attached by bind.
// Assumes: wr_ack only while wr_req is high; a command-only write of
// register 0x00 is a null command; one-byte 0xB0/0x00 closes shutdown.
module pnl_power_seq_chk #(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned WAIT_MS = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        en_req,
    input logic        wr_req,
    input logic [1:0]  wr_len,
    input logic [7:0]  wr_reg,
    input logic [15:0] wr_data,
    input logic        wr_ack,
    input logic        wr_err,
    input logic        active,
    input logic        err_flag
);

    localparam int unsigned RAW_CYC  = (CLK_HZ / 1000) * WAIT_MS;
    localparam int unsigned WAIT_CYC = (RAW_CYC == 0) ? 1 : RAW_CYC;

    logic        null_ack;
    logic        abort_hold;
    int unsigned gap_cnt;

    assign null_ack = wr_ack && (wr_len == 2'd1) && (wr_reg == 8'h00);

    // Count the cycles still owed after a successful null command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= 0;
        end else if (null_ack && !wr_err) begin
            gap_cnt <= WAIT_CYC;
        end else if (gap_cnt != 0) begin
            gap_cnt <= gap_cnt - 1;
        end
    end

    // Remember an aborted wake-up until the next enable request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_hold <= 1'b0;
        end else if (en_req) begin
            abort_hold <= 1'b0;
        end else if (null_ack && wr_err) begin
            abort_hold <= 1'b1;
        end
    end

    a_r3_null_gap: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> gap_cnt == 0);

    a_r4_abort_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (null_ack && wr_err) |=> (err_flag && !active));

    a_r4_abort_silent: assert property (@(posedge clk) disable iff (!rst_n)
        abort_hold |-> !wr_req);

    a_r5_len_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> wr_len != 2'd0);

    a_r6_active_after_on: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && wr_len == 2'd1 && wr_reg == 8'h29) |=> ##1 active);

    a_r7_err_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> ($rose(active) || $past(null_ack && wr_err)));

    a_r8_inactive_after_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && wr_len == 2'd2 && wr_reg == 8'hB0 && wr_data[7:0] == 8'h00)
        |=> ##1 !active);

    a_r9_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable({wr_len, wr_reg, wr_data})));

    a_r10_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_flag) |-> (wr_req && wr_len == 2'd1 && wr_reg == 8'h00 && !active));

endmodule

bind pnl_power_seq pnl_power_seq_chk #(
    .CLK_HZ  (CLK_HZ),
    .WAIT_MS (WAIT_MS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_req   (en_req),
    .wr_req   (wr_req),
    .wr_len   (wr_len),
    .wr_reg   (wr_reg),
    .wr_data  (wr_data),
    .wr_ack   (wr_ack),
    .wr_err   (wr_err),
    .active   (active),
    .err_flag (err_flag)
);

// File: tb/sim_pnl_power_seq.sv
// Bench: behavioural reference model (queues of expected writes plus
// a status model) compared with the design on every falling edge.
module sim_pnl_power_seq;

    localparam int CLK_HZ   = 10_000;
    localparam int WAIT_MS  = 1;
    localparam int WAIT_CYC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_req = 1'b0;
    logic        dis_req = 1'b0;
    logic        wr_ack = 1'b0;
    logic        wr_err = 1'b0;
    logic        wr_req;
    logic [1:0]  wr_len;
    logic [7:0]  wr_reg;
    logic [15:0] wr_data;
    logic        active;
    logic        err_flag;

    always #10 clk = ~clk;

    pnl_power_seq #(.CLK_HZ(CLK_HZ), .WAIT_MS(WAIT_MS)) u0 (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .wr_req(wr_req), .wr_len(wr_len), .wr_reg(wr_reg), .wr_data(wr_data),
        .wr_ack(wr_ack), .wr_err(wr_err), .active(active), .err_flag(err_flag)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [25:0] wake_list[$];
    logic [25:0] down_list[$];
    logic [25:0] exp_q[$];

    bit m_active = 0, m_err = 0, m_busy = 0, m_wake = 0, m_acc = 0;
    int m_txn = 0;
    int pend_cnt = 0;
    bit pend_active = 0, pend_err = 0, pend_free = 0;
    int ack_dly = 0, wait_cnt = 0, err_at = -1, tx_total = 0, gap = -1;

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [25:0] ent(logic [1:0] l, logic [7:0] r, logic [15:0] d);
        return {l, r, d};
    endfunction

    task automatic build_lists();
        for (int i = 0; i < 3; i++) wake_list.push_back(ent(2'd1, 8'h00, 16'h0));
        wake_list.push_back(ent(2'd2, 8'hB0, 16'h17));
        wake_list.push_back(ent(2'd2, 8'hBC, 16'h80));
        wake_list.push_back(ent(2'd2, 8'h3B, 16'h00));
        wake_list.push_back(ent(2'd2, 8'hB0, 16'h16));
        wake_list.push_back(ent(2'd3, 8'hB8, 16'hFFF9));
        wake_list.push_back(ent(2'd1, 8'h11, 16'h0));
        wake_list.push_back(ent(2'd2, 8'hBA, 16'h01));
        wake_list.push_back(ent(2'd2, 8'hBB, 16'h00));
        wake_list.push_back(ent(2'd2, 8'h3A, 16'h60));
        wake_list.push_back(ent(2'd2, 8'hBF, 16'h10));
        wake_list.push_back(ent(2'd2, 8'hB1, 16'h56));
        wake_list.push_back(ent(2'd2, 8'hB2, 16'h33));
        wake_list.push_back(ent(2'd2, 8'hB3, 16'h11));
        wake_list.push_back(ent(2'd2, 8'hB3, 16'h11));
        wake_list.push_back(ent(2'd2, 8'hB4, 16'h02));
        wake_list.push_back(ent(2'd2, 8'hB5, 16'h2B));
        wake_list.push_back(ent(2'd2, 8'hB6, 16'h40));
        wake_list.push_back(ent(2'd2, 8'hB7, 16'h03));
        wake_list.push_back(ent(2'd2, 8'hB9, 16'h04));
        wake_list.push_back(ent(2'd2, 8'hBD, 16'h04));
        wake_list.push_back(ent(2'd2, 8'hBE, 16'h00));
        wake_list.push_back(ent(2'd2, 8'hC0, 16'h11));
        wake_list.push_back(ent(2'd2, 8'hC1, 16'h11));
        wake_list.push_back(ent(2'd2, 8'hC2, 16'h11));
        wake_list.push_back(ent(2'd3, 8'hC3, 16'h2040));
        wake_list.push_back(ent(2'd3, 8'hC4, 16'h60C0));
        wake_list.push_back(ent(2'd3, 8'hC5, 16'h1020));
        wake_list.push_back(ent(2'd3, 8'hC6, 16'h60C0));
        wake_list.push_back(ent(2'd3, 8'hC7, 16'h5533));
        wake_list.push_back(ent(2'd2, 8'hC8, 16'h00));
        wake_list.push_back(ent(2'd2, 8'hC9, 16'h00));
        wake_list.push_back(ent(2'd2, 8'hCA, 16'h00));
        wake_list.push_back(ent(2'd3, 8'hEC, 16'h01F0));
        wake_list.push_back(ent(2'd2, 8'hCF, 16'h02));
        wake_list.push_back(ent(2'd3, 8'hD0, 16'h0804));
        wake_list.push_back(ent(2'd2, 8'hD1, 16'h01));
        wake_list.push_back(ent(2'd3, 8'hD2, 16'h0000));
        wake_list.push_back(ent(2'd3, 8'hD3, 16'h0D0E));
        wake_list.push_back(ent(2'd3, 8'hD4, 16'h11A4));
        wake_list.push_back(ent(2'd2, 8'hD5, 16'h0E));
        wake_list.push_back(ent(2'd1, 8'h29, 16'h0));
        down_list.push_back(ent(2'd1, 8'h28, 16'h0));
        down_list.push_back(ent(2'd3, 8'hB8, 16'h8002));
        down_list.push_back(ent(2'd1, 8'h10, 16'h0));
        down_list.push_back(ent(2'd2, 8'hB0, 16'h00));
    endtask

    // Monitor, reference model and writer responder, all on the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            if (pend_cnt > 0) begin
                pend_cnt--;
                if (pend_cnt == 0) begin
                    m_active = pend_active;
                    m_err    = pend_err;
                    if (pend_free) m_busy = 0;
                end
            end
            chk(active === m_active, "R6", "active per cycle", 32'(active), 32'(m_active));
            chk(err_flag === m_err, "R7", "err_flag per cycle", 32'(err_flag), 32'(m_err));
            wr_ack = 1'b0;
            wr_err = 1'b0;
            if (wr_req) begin
                if (gap >= 0) begin
                    chk(gap >= WAIT_CYC, "R3", "pause after null", 32'(gap), 32'(WAIT_CYC));
                    gap = -1;
                end
                if (wait_cnt < ack_dly) begin
                    wait_cnt++;
                end else begin
                    logic [25:0] ex;
                    bit e;
                    wait_cnt = 0;
                    e = (tx_total == err_at);
                    tx_total++;
                    wr_ack = 1'b1;
                    wr_err = e;
                    if (exp_q.size() == 0) begin
                        chk(0, "R2", "unexpected write", 32'({wr_len, wr_reg, wr_data}), 32'h0);
                    end else begin
                        ex = exp_q.pop_front();
                        chk({wr_len, wr_reg, wr_data} === ex,
                            (m_wake && m_txn < 3) ? "R3" : (m_wake ? "R5" : "R8"),
                            "write payload", 32'({wr_len, wr_reg, wr_data}), 32'(ex));
                        if (m_wake && m_txn < 3) begin
                            if (e) begin
                                exp_q.delete();
                                pend_cnt = 1; pend_active = 0; pend_err = 1; pend_free = 1;
                            end else begin
                                gap = 0;
                            end
                        end else begin
                            if (m_wake) m_acc = m_acc | e;
                            if (exp_q.size() == 0) begin
                                pend_cnt = 2;
                                pend_active = m_wake;
                                pend_err = m_wake ? m_acc : m_err;
                                pend_free = 1;
                            end
                        end
                        m_txn++;
                    end
                end
            end else if (gap >= 0) begin
                gap++;
            end
            if (en_req && !m_busy && !m_active) begin
                m_busy = 1; m_wake = 1; m_acc = 0; m_txn = 0;
                exp_q = wake_list;
                pend_cnt = 1; pend_active = m_active; pend_err = 0; pend_free = 0;
            end else if (dis_req && !m_busy && m_active) begin
                m_busy = 1; m_wake = 0; m_txn = 0;
                exp_q = down_list;
            end
        end
    end

    task automatic pulse_en();
        @(posedge clk); #2 en_req = 1'b1;
        @(posedge clk); #2 en_req = 1'b0;
    endtask

    task automatic pulse_dis();
        @(posedge clk); #2 dis_req = 1'b1;
        @(posedge clk); #2 dis_req = 1'b0;
    endtask

    task automatic wait_quiet();
        do @(posedge clk); while (m_busy || pend_cnt != 0);
        repeat (3) @(posedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // Stimulus: one scenario per requirement group.
    initial begin
        int t0;
        build_lists();
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(active === 1'b0, "R1", "active after reset", 32'(active), 32'h0);
        chk(err_flag === 1'b0, "R1", "err_flag after reset", 32'(err_flag), 32'h0);
        chk(wr_req === 1'b0, "R1", "wr_req after reset", 32'(wr_req), 32'h0);

        t0 = tx_total;
        pulse_dis();
        repeat (30) @(posedge clk);
        chk(tx_total == t0, "R2", "disable while inactive writes", 32'(tx_total - t0), 32'h0);
        chk(active === 1'b0, "R2", "disable while inactive status", 32'(active), 32'h0);

        ack_dly = 0; t0 = tx_total;
        pulse_en();
        wait_quiet();
        chk(tx_total - t0 == 44, "R5", "wake-up write count", 32'(tx_total - t0), 32'd44);
        chk(active === 1'b1, "R6", "active after wake-up", 32'(active), 32'h1);
        chk(err_flag === 1'b0, "R7", "clean wake-up error", 32'(err_flag), 32'h0);

        t0 = tx_total;
        pulse_en();
        repeat (30) @(posedge clk);
        chk(tx_total == t0, "R2", "enable while active writes", 32'(tx_total - t0), 32'h0);

        ack_dly = 2; t0 = tx_total;
        pulse_dis();
        wait_quiet();
        chk(tx_total - t0 == 4, "R8", "shutdown write count", 32'(tx_total - t0), 32'd4);
        chk(active === 1'b0, "R8", "inactive after shutdown", 32'(active), 32'h0);

        ack_dly = 1; t0 = tx_total; err_at = tx_total + 20;
        pulse_en();
        wait_quiet();
        chk(tx_total - t0 == 44, "R7", "late error keeps going", 32'(tx_total - t0), 32'd44);
        chk(err_flag === 1'b1, "R7", "late error reported", 32'(err_flag), 32'h1);
        chk(active === 1'b1, "R7", "active despite late error", 32'(active), 32'h1);

        t0 = tx_total; err_at = tx_total + 1;
        pulse_dis();
        wait_quiet();
        chk(err_flag === 1'b1, "R10", "sticky through shutdown", 32'(err_flag), 32'h1);
        chk(tx_total - t0 == 4, "R8", "shutdown with error count", 32'(tx_total - t0), 32'd4);

        ack_dly = 0; t0 = tx_total; err_at = tx_total + 1;
        pulse_en();
        wait_quiet();
        repeat (20) @(posedge clk);
        chk(tx_total - t0 == 2, "R4", "writes before abort", 32'(tx_total - t0), 32'd2);
        chk(err_flag === 1'b1, "R4", "error after abort", 32'(err_flag), 32'h1);
        chk(active === 1'b0, "R4", "inactive after abort", 32'(active), 32'h0);

        err_at = -1; t0 = tx_total;
        pulse_en();
        repeat (6) @(posedge clk);
        chk(err_flag === 1'b0, "R10", "error cleared at start", 32'(err_flag), 32'h0);
        pulse_en();
        pulse_dis();
        wait_quiet();
        chk(tx_total - t0 == 44, "R2", "requests mid-sequence ignored", 32'(tx_total - t0), 32'd44);
        chk(active === 1'b1, "R6", "active after retry", 32'(active), 32'h1);

        done = 1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100_000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R5 watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule